// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the purely combinational arithmetic and logic unit of a small accumulator core. It receives an operation code, two byte operands and the current value of the five status flags. From these it produces the byte result, the candidate next value of every flag and a write-enable per flag. The carry-in for add-with-carry and for the rotates through carry is taken from the C bit of the current status.

Each operation class writes only its own subset of the flags. A flag whose write-enable is low is passed through unchanged from the status input, so the surrounding core can load the flag register with the output on every instruction. Overflow comes from the internal carries of the adder and not from a comparison of signs. Instruction decode and register writeback belong to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: The flag vector is ordered bit4=N, bit3=OV, bit2=Z, bit1=DC, bit0=C. ADD (op 0) gives result (a+b) mod 256, with C set on a carry out of bit 7 and DC set on a carry out of bit 3.
- R2: For every arithmetic operation, OV equals the carry out of bit 7 XOR the carry into bit 7. That is, OV is set exactly when both addends have the same sign and the result has the other sign.
- R3: ADDC (op 1) adds a, b and the incoming C bit (status bit 0), and its carries include that bit.
- R4: SUB (op 2) adds a to the two's complement of b modulo 256. INC (op 3) adds 1 to a and DEC (op 4) adds 0xFF to a. All three set C, DC and OV by the addition rules of R1 and R2.
- R5: For every operation that writes N and Z, N equals result bit 7 and Z is 1 exactly when the result is zero.
- R6: AND (op 5), OR (op 6) and XOR (op 7) combine a with b bitwise and write only N and Z (write-enable mask 5'b10100).
- R7: RLC (op 11) returns {a[6:0], C} with the new C = a[7]. RRC (op 12) returns {C, a[7:1]} with the new C = a[0]. Both write C, N and Z (mask 5'b10101).
- R8: RLN (op 9) returns {a[6:0], a[7]} and RRN (op 10) returns {a[0], a[7:1]}. Both write only N and Z.
- R9: SWAP (op 8) returns {a[3:0], a[7:4]} and writes no flag.
- R10: PASS (op 13) and the reserved code 15 return a and write no flag. TEST (op 14) returns a and writes N and Z.
- R11: Every flag whose write-enable is 0 is output equal to its status input bit. Arithmetic ops assert all five write-enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (the one rotated, swapped and passed) |
| b_i | input | 8 | Second operand |
| status_i | input | 5 | Current flags {N,OV,Z,DC,C}; bit 0 is carry-in |
| result_o | output | 8 | Operation result |
| flags_o | output | 5 | Next flags; unwritten bits equal status_i |
| flag_we_o | output | 5 | Per-flag write-enable, same bit order |

## Verification
The bench drives additions that cross 0x7F to 0x80 and 0x80 to 0x7F. A design that derives OV from the carry out alone sets the flag at 0xFF+0x01 and misses it at 0x7F+0x01. Nibble-edge sums such as 0x0F+0x01 catch a DC taken from the wrong carry bit. SUB with b=0 and DEC of 0x00 catch an off-by-one in the negated operand. Rotates through carry are run with both incoming C values, which exposes a design that drops the old carry or takes the new C from the wrong end. Every op also runs with status bits set that the op must not write, so a leaking write-enable shows up as a changed flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int NFLAGS = 5;
  localparam int FL_C  = 0;
  localparam int FL_DC = 1;
  localparam int FL_Z  = 2;
  localparam int FL_OV = 3;
  localparam int FL_N  = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_INC  = 4'd3,
    OP_DEC  = 4'd4,  OP_AND  = 4'd5,  OP_OR   = 4'd6,  OP_XOR  = 4'd7,
    OP_SWAP = 4'd8,  OP_RLN  = 4'd9,  OP_RRN  = 4'd10, OP_RLC  = 4'd11,
    OP_RRC  = 4'd12, OP_PASS = 4'd13, OP_TEST = 4'd14, OP_RSVD = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR} logic_sel_e;
  typedef enum logic [2:0] {RT_SWAP, RT_LN, RT_RN, RT_LC, RT_RC} rot_sel_e;
  typedef enum logic [2:0] {CL_ARITH, CL_LOGIC, CL_ROT, CL_ROTC, CL_MOVE, CL_TEST} op_class_e;

  localparam logic [NFLAGS-1:0] WE_ALL  = 5'b11111;
  localparam logic [NFLAGS-1:0] WE_NZ   = 5'b10100;
  localparam logic [NFLAGS-1:0] WE_NZC  = 5'b10101;
  localparam logic [NFLAGS-1:0] WE_NONE = 5'b00000;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         dc_o,
  output logic         ov_o
);
  localparam int HALF = W / 2;

  logic [W:0] usum;
  logic       c_into_msb;

  assign usum       = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o      = usum[W-1:0];
  assign c_o        = usum[W];
  // carry into a bit = sum bit xor both operand bits
  assign dc_o       = usum[HALF] ^ a_i[HALF] ^ b_i[HALF];
  assign c_into_msb = usum[W-1] ^ a_i[W-1] ^ b_i[W-1];
  assign ov_o       = usum[W] ^ c_into_msb;

  always_comb begin
    assert_ov_sign_R2: assert (ov_o == ((a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1])))
      else $error("OV disagrees with operand/result signs");
    assert_dc_nibble_R1: assert (dc_o == (({1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]}
                                           + {{HALF{1'b0}}, cin_i}) >> HALF != 0))
      else $error("DC disagrees with low-half carry");
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  rot_sel_e     sel_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam int HALF = W / 2;

  logic [W-1:0] rot_l, rot_r, swp;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bits
      assign rot_l[i] = a_i[(i + W - 1) % W];
      assign rot_r[i] = a_i[(i + 1) % W];
      assign swp[i]   = a_i[(i + HALF) % W];
    end
  endgenerate

  always_comb begin
    cout_o = cin_i;
    unique case (sel_i)
      RT_SWAP: res_o = swp;
      RT_LN:   res_o = rot_l;
      RT_RN:   res_o = rot_r;
      RT_LC: begin
        res_o  = {a_i[W-2:0], cin_i};
        cout_o = a_i[W-1];
      end
      default: begin
        res_o  = {cin_i, a_i[W-1:1]};
        cout_o = a_i[0];
      end
    endcase
  end

  always_comb begin
    if (sel_i == RT_LC || sel_i == RT_RC) begin
      assert_rotc_bits_kept_R7: assert ($countones({cout_o, res_o}) == $countones({cin_i, a_i}))
        else $error("rotate through carry lost a bit");
    end else begin
      assert_rot_bits_kept_R8: assert ($countones(res_o) == $countones(a_i))
        else $error("byte rotate lost a bit");
    end
  end
endmodule

// File: rtl/alu8_flag_ctl.sv
module alu8_flag_ctl
  import alu8_pkg::*;
(
  input  alu_op_e            op_i,
  output op_class_e          cls_o,
  output logic [NFLAGS-1:0]  we_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD, OP_ADDC, OP_SUB, OP_INC, OP_DEC: cls_o = CL_ARITH;
      OP_AND, OP_OR, OP_XOR:                   cls_o = CL_LOGIC;
      OP_RLN, OP_RRN:                          cls_o = CL_ROT;
      OP_RLC, OP_RRC:                          cls_o = CL_ROTC;
      OP_TEST:                                 cls_o = CL_TEST;
      default:                                 cls_o = CL_MOVE;
    endcase
  end

  always_comb begin
    unique case (cls_o)
      CL_ARITH:                   we_o = WE_ALL;
      CL_LOGIC, CL_ROT, CL_TEST:  we_o = WE_NZ;
      CL_ROTC:                    we_o = WE_NZC;
      default:                    we_o = WE_NONE;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [NFLAGS-1:0] status_i,
  output logic [W-1:0]      result_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic [NFLAGS-1:0] flag_we_o
);
  localparam int HALF = W / 2;

  alu_op_e             op;
  op_class_e           cls;
  logic [W-1:0]        addend, add_res, lg_res, rt_res;
  logic                add_cin, add_c, add_dc, add_ov, rt_c;
  logic_sel_e          lg_sel;
  rot_sel_e            rt_sel;
  logic [NFLAGS-1:0]   cand;

  assign op = alu_op_e'(op_i);

  always_comb begin
    add_cin = 1'b0;
    unique case (op)
      OP_SUB:  addend = W'(~b_i + W'(1));
      OP_INC:  addend = W'(1);
      OP_DEC:  addend = '1;
      OP_ADDC: begin
        addend  = b_i;
        add_cin = status_i[FL_C];
      end
      default: addend = b_i;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_XOR;
    endcase
    unique case (op)
      OP_SWAP: rt_sel = RT_SWAP;
      OP_RLN:  rt_sel = RT_LN;
      OP_RRN:  rt_sel = RT_RN;
      OP_RLC:  rt_sel = RT_LC;
      default: rt_sel = RT_RC;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(addend), .cin_i(add_cin),
    .sum_o(add_res), .c_o(add_c), .dc_o(add_dc), .ov_o(add_ov)
  );

  alu8_logic #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i), .sel_i(lg_sel), .res_o(lg_res)
  );

  alu8_rotate #(.W(W)) u_rotate (
    .a_i(a_i), .cin_i(status_i[FL_C]), .sel_i(rt_sel),
    .res_o(rt_res), .cout_o(rt_c)
  );

  alu8_flag_ctl u_flag_ctl (
    .op_i(op), .cls_o(cls), .we_o(flag_we_o)
  );

  always_comb begin
    unique case (cls)
      CL_ARITH:        result_o = add_res;
      CL_LOGIC:        result_o = lg_res;
      CL_ROT, CL_ROTC: result_o = rt_res;
      default:         result_o = (op == OP_SWAP) ? rt_res : a_i;
    endcase
  end

  always_comb begin
    cand        = '0;
    cand[FL_N]  = result_o[W-1];
    cand[FL_Z]  = (result_o == '0);
    cand[FL_OV] = add_ov;
    cand[FL_DC] = add_dc;
    cand[FL_C]  = (cls == CL_ROTC) ? rt_c : add_c;
  end

  generate
    for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
      assign flags_o[f] = flag_we_o[f] ? cand[f] : status_i[f];
    end
  endgenerate

  always_comb begin
    if (flag_we_o[FL_Z]) begin
      assert_zero_flag_R5: assert (flags_o[FL_Z] == (result_o == '0))
        else $error("Z does not match result");
    end
    if (op == OP_SWAP) begin
      assert_swap_quiet_R9: assert (flags_o == status_i && result_o == {a_i[HALF-1:0], a_i[W-1:HALF]})
        else $error("swap touched flags or misordered halves");
    end
    if (cls == CL_LOGIC) begin
      assert_logic_keeps_arith_flags_R6: assert (flags_o[FL_C] == status_i[FL_C]
                                                 && flags_o[FL_DC] == status_i[FL_DC]
                                                 && flags_o[FL_OV] == status_i[FL_OV])
        else $error("logic op changed an arithmetic flag");
    end
  end
endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op;
  logic [7:0] a, b;
  logic [4:0] st;
  logic [7:0] res;
  logic [4:0] fl, we;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu8_core dut_i (
    .op_i(op), .a_i(a), .b_i(b), .status_i(st),
    .result_o(res), .flags_o(fl), .flag_we_o(we)
  );

  // independent reference: {result, flags, we}; flags bit4..0 = N OV Z DC C
  function automatic logic [17:0] model(input logic [3:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic [4:0] s);
    int ua, ux, ci, sum, sa, sx, ss;
    logic [7:0] r;
    logic [4:0] nf, m;
    logic do_add;
    ua = int'(x); ci = 0; ux = 0; do_add = 1'b0;
    r = x; nf = 5'b0; m = 5'b0;
    case (o)
      4'd0: begin ux = int'(y); do_add = 1; end
      4'd1: begin ux = int'(y); ci = int'(s[0]); do_add = 1; end
      4'd2: begin ux = (256 - int'(y)) % 256; do_add = 1; end
      4'd3: begin ux = 1; do_add = 1; end
      4'd4: begin ux = 255; do_add = 1; end
      4'd5: begin r = x & y; m = 5'b10100; end
      4'd6: begin r = x | y; m = 5'b10100; end
      4'd7: begin r = x ^ y; m = 5'b10100; end
      4'd8: begin r = {x[3:0], x[7:4]}; end
      4'd9: begin r = {x[6:0], x[7]}; m = 5'b10100; end
      4'd10: begin r = {x[0], x[7:1]}; m = 5'b10100; end
      4'd11: begin r = {x[6:0], s[0]}; nf[0] = x[7]; m = 5'b10101; end
      4'd12: begin r = {s[0], x[7:1]}; nf[0] = x[0]; m = 5'b10101; end
      4'd14: begin m = 5'b10100; end
      default: ;
    endcase
    if (do_add) begin
      sum = ua + ux + ci;
      r = 8'(sum % 256);
      nf[0] = (sum > 255);
      nf[1] = ((ua % 16) + (ux % 16) + ci) > 15;
      sa = (ua > 127) ? ua - 256 : ua;
      sx = (ux > 127) ? ux - 256 : ux;
      ss = sa + sx + ci;
      nf[3] = (ss > 127) || (ss < -128);
      m = 5'b11111;
    end
    nf[4] = r[7];
    nf[2] = (r == 8'h00);
    return {r, (nf & m) | (s & ~m), m};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic apply_op(input string req, input logic [3:0] o, input logic [7:0] x,
                          input logic [7:0] y, input logic [4:0] s);
    logic [17:0] e;
    @(negedge clk);
    op = o; a = x; b = y; st = s;
    #1;
    e = model(o, x, y, s);
    check(req, $sformatf("op%0d res a=%0h b=%0h", o, x, y), int'(res), int'(e[17:10]));
    check(req, $sformatf("op%0d flags st=%0h", o, s), int'(fl), int'(e[9:5]));
    check(req, $sformatf("op%0d we", o), int'(we), int'(e[4:0]));
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    check("R1", "reset-state result", int'(res), 0);
    check("R5", "reset-state Z", int'(fl[2]), 1);
  endtask

  task automatic t_add;
    apply_op("R1", 4'd0, 8'h0F, 8'h01, 5'b0);
    check("R1", "DC on 0F+01", int'(fl[1]), 1);
    apply_op("R1", 4'd0, 8'hFF, 8'h01, 5'b0);
    check("R1", "C on FF+01", int'(fl[0]), 1);
    check("R2", "no OV on FF+01", int'(fl[3]), 0);
    apply_op("R2", 4'd0, 8'h7F, 8'h01, 5'b0);
    check("R2", "OV on 7F+01", int'(fl[3]), 1);
    check("R5", "N on 7F+01", int'(fl[4]), 1);
    apply_op("R2", 4'd0, 8'h80, 8'h80, 5'b0);
    check("R2", "OV on 80+80", int'(fl[3]), 1);
    check("R5", "Z on 80+80", int'(fl[2]), 1);
  endtask

  task automatic t_addc;
    apply_op("R3", 4'd1, 8'h10, 8'h20, 5'b00001);
    check("R3", "ADDC result", int'(res), 8'h31);
    apply_op("R3", 4'd1, 8'h0F, 8'h00, 5'b00001);
    check("R3", "ADDC DC from carry-in", int'(fl[1]), 1);
    apply_op("R3", 4'd1, 8'h7F, 8'h00, 5'b00001);
    check("R3", "ADDC OV from carry-in", int'(fl[3]), 1);
  endtask

  task automatic t_sub_incdec;
    apply_op("R4", 4'd2, 8'h05, 8'h03, 5'b0);
    check("R4", "SUB 5-3", int'(res), 2);
    apply_op("R4", 4'd2, 8'h05, 8'h00, 5'b00001);
    check("R4", "SUB b=0 C", int'(fl[0]), 0);
    apply_op("R4", 4'd2, 8'h80, 8'h01, 5'b0);
    check("R4", "SUB 80-01 OV", int'(fl[3]), 1);
    apply_op("R4", 4'd3, 8'hFF, 8'h00, 5'b0);
    check("R4", "INC FF wraps", int'(res), 0);
    apply_op("R4", 4'd4, 8'h00, 8'h00, 5'b0);
    check("R4", "DEC 00", int'(res), 8'hFF);
    check("R4", "DEC 00 C clear", int'(fl[0]), 0);
  endtask

  task automatic t_logic;
    apply_op("R6", 4'd5, 8'hF0, 8'h0F, 5'b01011);
    check("R6", "AND zero keeps C/DC/OV", int'(fl), 5'b01111);
    apply_op("R6", 4'd6, 8'h80, 8'h01, 5'b00000);
    apply_op("R6", 4'd7, 8'hAA, 8'hAA, 5'b11011);
  endtask

  task automatic t_rot;
    apply_op("R7", 4'd11, 8'h80, 8'h00, 5'b00000);
    check("R7", "RLC 80 C0 gives C=1", int'(fl[0]), 1);
    check("R7", "RLC 80 C0 result", int'(res), 0);
    apply_op("R7", 4'd11, 8'h01, 8'h00, 5'b00001);
    check("R7", "RLC 01 C1 result", int'(res), 8'h03);
    apply_op("R7", 4'd12, 8'h01, 8'h00, 5'b00001);
    check("R7", "RRC 01 C1 result", int'(res), 8'h80);
    check("R7", "RRC 01 C1 new C", int'(fl[0]), 1);
    apply_op("R8", 4'd9, 8'h81, 8'h00, 5'b01011);
    check("R8", "RLN 81", int'(res), 8'h03);
    check("R8", "RLN keeps C/DC/OV", int'(fl[3:0] & 4'b1011), 4'b1011);
    apply_op("R8", 4'd10, 8'h01, 8'h00, 5'b0);
    check("R8", "RRN 01", int'(res), 8'h80);
  endtask

  task automatic t_swap_move;
    apply_op("R9", 4'd8, 8'h3C, 8'h00, 5'b10101);
    check("R9", "SWAP result", int'(res), 8'hC3);
    check("R9", "SWAP flags untouched", int'(fl), 5'b10101);
    apply_op("R10", 4'd13, 8'h00, 8'h55, 5'b01010);
    check("R10", "PASS flags untouched", int'(fl), 5'b01010);
    apply_op("R10", 4'd15, 8'h9A, 8'h00, 5'b0);
    apply_op("R10", 4'd14, 8'h00, 8'h00, 5'b01011);
    check("R10", "TEST sets Z keeps rest", int'(fl), 5'b01111);
  endtask

  task automatic t_sweep;
    logic [7:0] v;
    v = 8'h5A;
    for (int i = 0; i < 400; i++) begin
      v = {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
      apply_op("R11", 4'(i % 16), v, 8'(v * 8'd37 + 8'(i)), 5'(i * 7));
    end
  endtask

  initial begin
    op = 4'd0; a = 8'h00; b = 8'h00; st = 5'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_add();
    t_addc();
    t_sub_incdec();
    t_logic();
    t_rot();
    t_swap_move();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule